// File: doc/BRIEF.md
# Interval Timer Host Byte Port

This block is the eight-bit host-facing front end of a multi-channel interval timer. A host writes and reads single bytes at a two-bit address. Address 3 accepts setup commands (per-channel configuration, a snapshot of one channel's count, or a combined snapshot command for several channels at once). Addresses 0 to 2 carry count bytes to and from the channel with that number.

Each channel keeps its own byte-ordering state. That state decides whether a data byte is a low byte, a high byte, or one half of a two-byte pair. Each channel also holds a frozen copy of its count and of its status byte. The counters themselves sit outside the block. They receive an operating mode, a BCD flag, a one-cycle load strobe and a sixteen-bit load value. In return they present their running count and their output level.

Read data is combinational. `rdata` always shows the byte that a read strobe at the current address would return. All state changes take effect on the rising clock edge at which a strobe is high.

Top module: `tmr_host_port`

## Requirements
- R1: A write at address 3 with bits 7:6 equal to a channel number c below 3 and a nonzero access field in bits 5:4 sets channel c as follows. Its access mode takes bits 5:4, with 01 meaning low byte only, 10 meaning high byte only and 11 meaning a low/high pair. Its operating mode `ch_mode[3c+2:3c]` takes bits 3:1, and its `ch_bcd[c]` takes bit 0. Both its write and its read byte order restart at the low byte.
- R2: A control write with access field 00 freezes channel c's current `ch_count` as a latched count. It leaves the access mode, operating mode and BCD flag unchanged. The request is ignored while an earlier latched count of that channel is still unread.
- R3: In low-only mode a data write pulses `ch_load[c]` in the same cycle with value {8'h00, byte}. In high-only mode the value is {byte, 8'h00}.
- R4: In pair mode the first data write only stores the byte and gives no load strobe. The second write loads {second, first}, and the next write is again treated as a low byte.
- R5: A write at address 3 with bits 7:6 = 11 is a snapshot command. Bit c+1 selects channel c. Bit 5 at 0 requests a count latch for each selected channel, under the same rule as R2. Bit 4 at 0 latches the status byte {out level, 0, access[1:0], mode[2:0], bcd}, unless a status byte is already held.
- R6: A data read returns the held status byte first and releases it. Without a held status byte it returns the latched count. Without either it returns the live count.
- R7: In pair mode a latched count reads out low byte then high byte and is released after the high byte. In low-only mode it reads out as the low byte, in high-only mode as the high byte, and it is released after that one read.
- R8: A live read returns the low byte in low-only mode and the high byte in high-only mode. In pair mode it alternates, starting with the low byte.
- R9: Address 3 always reads 0, and a read there changes no state.
- R10: After reset every channel is in pair mode with operating mode 0, BCD 0, no latches held, and both byte orders at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Byte address: 0..2 channel data, 3 command |
| wr_en | input | 1 | Write strobe, one byte per high cycle |
| rd_en | input | 1 | Read strobe, one byte per high cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte returned for the current address |
| ch_count | input | NUM_CH*16 | Live count of each channel, channel 0 in the low bits |
| ch_out | input | NUM_CH | Output level of each channel |
| ch_mode | output | NUM_CH*3 | Operating mode of each channel |
| ch_bcd | output | NUM_CH | BCD flag of each channel |
| ch_load | output | NUM_CH | One-cycle load strobe of each channel |
| ch_load_val | output | NUM_CH*16 | Load value of each channel |

## Verification
Directed sequences first show each access mode in isolation. A single low byte, a single high byte and a byte pair each produce a distinct load value, which separates a swapped or zero-filled half from a correct one. Latch sequences change the live count between the snapshot and the read, and issue a second snapshot request before the first is read. The value read back therefore tells a frozen count from a live one, and an ignored second request from an overwrite. Constrained random traffic then mixes control words, snapshot commands with every select pattern, and reads and writes on all four addresses. This exposes interactions among status, latched-count and live-count priority and the byte-order state.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD  = 2'b11
   } acc_e;

   // latched-count read state; values line up with acc_e on capture
   typedef enum logic [1:0] {
      CL_NONE = 2'b00,
      CL_LO   = 2'b01,
      CL_HI   = 2'b10,
      CL_WORD = 2'b11
   } clat_e;

   function automatic logic [BYTE_W-1:0] status_byte(input logic out_lvl, input acc_e acc,
                                                     input logic [2:0] mode, input logic bcd);
      return {out_lvl, 1'b0, acc, mode, bcd};
   endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
   parameter int NUM_CH = 3
) (
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [NUM_CH-1:0] cw_wr,
   output logic [NUM_CH-1:0] cnt_req,
   output logic [NUM_CH-1:0] st_req,
   output logic [NUM_CH-1:0] data_wr,
   output logic [NUM_CH-1:0] data_rd
);
   localparam logic [1:0] CMD_ADDR = 2'd3;
   localparam logic [1:0] SNAP_SEL = 2'd3;

   logic       is_cmd, is_snap;
   logic [1:0] sel, acc;

   assign is_cmd  = wr_en && (addr == CMD_ADDR);
   assign sel     = wdata[7:6];
   assign acc     = wdata[5:4];
   assign is_snap = (sel == SNAP_SEL);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit        = !is_snap && (sel == 2'(c));
         assign cw_wr[c]   = is_cmd && hit && (acc != 2'b00);
         assign cnt_req[c] = is_cmd && ((hit && acc == 2'b00) ||
                                        (is_snap && wdata[c+1] && !wdata[5]));
         assign st_req[c]  = is_cmd && is_snap && wdata[c+1] && !wdata[4];
         assign data_wr[c] = wr_en && (addr == 2'(c));
         assign data_rd[c] = rd_en && (addr == 2'(c));
      end
   endgenerate
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
   import tmr_host_pkg::*;
#(
   parameter logic [2:0] RST_MODE = 3'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_wr,
   input  logic [1:0]        cw_acc,
   input  logic [2:0]        cw_mode,
   input  logic              cw_bcd,
   input  logic              cnt_req,
   input  logic              st_req,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              out_lvl,
   output logic [BYTE_W-1:0] rdata,
   output logic [2:0]        mode,
   output logic              bcd,
   output logic              load,
   output logic [CNT_W-1:0]  load_val
);
   acc_e              acc_q;
   clat_e             clat_q;
   logic [2:0]        mode_q;
   logic              bcd_q, wr_hi_q, rd_hi_q, st_q;
   logic [BYTE_W-1:0] hold_q, sval_q;
   logic [CNT_W-1:0]  cval_q;

   assign mode = mode_q;
   assign bcd  = bcd_q;

   always_comb begin
      load     = 1'b0;
      load_val = '0;
      if (data_wr) begin
         case (acc_q)
            ACC_LO:  begin load = 1'b1; load_val = {{BYTE_W{1'b0}}, wdata}; end
            ACC_HI:  begin load = 1'b1; load_val = {wdata, {BYTE_W{1'b0}}}; end
            default: if (wr_hi_q) begin load = 1'b1; load_val = {wdata, hold_q}; end
         endcase
      end
   end

   always_comb begin
      if (st_q)
         rdata = sval_q;
      else if (clat_q != CL_NONE)
         rdata = (clat_q == CL_HI) ? cval_q[CNT_W-1:BYTE_W] : cval_q[BYTE_W-1:0];
      else begin
         case (acc_q)
            ACC_LO:  rdata = live_cnt[BYTE_W-1:0];
            ACC_HI:  rdata = live_cnt[CNT_W-1:BYTE_W];
            default: rdata = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= ACC_WORD;
         mode_q  <= RST_MODE;
         bcd_q   <= 1'b0;
         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;
         hold_q  <= '0;
         clat_q  <= CL_NONE;
         cval_q  <= '0;
         st_q    <= 1'b0;
         sval_q  <= '0;
      end else begin
         if (data_wr && acc_q == ACC_WORD) begin
            if (!wr_hi_q) hold_q <= wdata;
            wr_hi_q <= !wr_hi_q;
         end
         if (data_rd) begin
            if (st_q)
               st_q <= 1'b0;
            else if (clat_q != CL_NONE)
               clat_q <= (clat_q == CL_WORD) ? CL_HI : CL_NONE;
            else if (acc_q == ACC_WORD)
               rd_hi_q <= !rd_hi_q;
         end
         if (cw_wr) begin
            acc_q   <= acc_e'(cw_acc);
            mode_q  <= cw_mode;
            bcd_q   <= cw_bcd;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
         if (cnt_req && clat_q == CL_NONE) begin
            cval_q <= live_cnt;
            clat_q <= clat_e'(acc_q);
         end
         if (st_req && !st_q) begin
            st_q   <= 1'b1;
            sval_q <= status_byte(out_lvl, acc_q, mode_q, bcd_q);
         end
      end
   end

   // R2: an unread latched count is not overwritten
   a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clat_q != CL_NONE && !data_rd) |=> $stable(cval_q));
   // R6: a read releases a held status byte
   a_r6_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && data_rd) |=> !st_q);
   // R7: pair-mode latch moves on to its high byte
   a_r7_word_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (clat_q == CL_WORD && data_rd && !st_q) |=> (clat_q == CL_HI));
   // R3: low-only loads keep the upper half clear
   a_r3_low_only_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (load && acc_q == ACC_LO) |-> (load_val[CNT_W-1:BYTE_W] == '0));
   // R8: live pair-mode reads alternate
   a_r8_live_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !st_q && clat_q == CL_NONE && acc_q == ACC_WORD && !cw_wr)
      |=> (rd_hi_q != $past(rd_hi_q)));
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
   import tmr_host_pkg::*;
#(
   parameter int         NUM_CH   = 3,
   parameter logic [2:0] RST_MODE = 3'd0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              addr,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   input  logic [NUM_CH*CNT_W-1:0] ch_count,
   input  logic [NUM_CH-1:0]       ch_out,
   output logic [NUM_CH*3-1:0]     ch_mode,
   output logic [NUM_CH-1:0]       ch_bcd,
   output logic [NUM_CH-1:0]       ch_load,
   output logic [NUM_CH*CNT_W-1:0] ch_load_val
);
   generate
      if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_num_ch
         $error("NUM_CH must lie in 1..3, the data addresses below the command address");
      end
      if (BYTE_W != 8) begin : g_bad_byte_w
         $error("BYTE_W must be 8 to match the port width");
      end
   endgenerate

   logic [NUM_CH-1:0] cw_wr, cnt_req, st_req, data_wr, data_rd;
   logic [BYTE_W-1:0] ch_rd [NUM_CH];

   tmr_cmd_decode #(.NUM_CH(NUM_CH)) i_dec (
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
      .cw_wr(cw_wr), .cnt_req(cnt_req), .st_req(st_req),
      .data_wr(data_wr), .data_rd(data_rd)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         tmr_chan_port #(.RST_MODE(RST_MODE)) i_chan (
            .clk(clk), .rst_n(rst_n),
            .cw_wr(cw_wr[c]), .cw_acc(wdata[5:4]), .cw_mode(wdata[3:1]), .cw_bcd(wdata[0]),
            .cnt_req(cnt_req[c]), .st_req(st_req[c]),
            .data_wr(data_wr[c]), .data_rd(data_rd[c]), .wdata(wdata),
            .live_cnt(ch_count[c*CNT_W +: CNT_W]), .out_lvl(ch_out[c]),
            .rdata(ch_rd[c]), .mode(ch_mode[c*3 +: 3]), .bcd(ch_bcd[c]),
            .load(ch_load[c]), .load_val(ch_load_val[c*CNT_W +: CNT_W])
         );
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (addr == 2'(c)) rdata = ch_rd[c];
   end

   // R9: the command address reads as zero
   a_r9_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> (rdata == 8'h00));
endmodule

// File: tb/test_tmr_host_port.sv
module test_tmr_host_port;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = CLK_PERIOD / 2;

   logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
   logic [1:0]  addr = 0;
   logic [7:0]  wdata = 0, rdata;
   logic [15:0] lcnt [3];
   logic [2:0]  lout = 0;
   logic [47:0] ch_count, ch_load_val;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd, ch_load;

   int n_chk = 0, n_fail = 0;

   // bench model of the requirements
   logic [1:0]  m_acc [3];
   logic [2:0]  m_mode [3];
   logic        m_bcd [3], m_wrhi [3], m_rdhi [3], m_slat [3];
   logic [7:0]  m_hold [3], m_sval [3];
   logic [1:0]  m_clat [3];
   logic [15:0] m_cval [3];

   assign ch_count = {lcnt[2], lcnt[1], lcnt[0]};

   always #(HALF) clk = ~clk;

   tmr_host_port i_tmr_host_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ch_out(lout),
      .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load), .ch_load_val(ch_load_val)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 3; c++) begin
         m_acc[c] = 2'b11; m_mode[c] = 0; m_bcd[c] = 0; m_wrhi[c] = 0; m_rdhi[c] = 0;
         m_slat[c] = 0; m_hold[c] = 0; m_sval[c] = 0; m_clat[c] = 0; m_cval[c] = 0;
      end
   endtask

   task automatic model_latch(input int c);
      if (m_clat[c] == 0) begin m_clat[c] = m_acc[c]; m_cval[c] = lcnt[c]; end
   endtask

   task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
      logic [2:0]  exp_ld;
      logic [15:0] exp_val;
      string tag;
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      #(HALF - 1);
      exp_ld = 0; exp_val = 0; tag = "R1";
      if (a != 3) begin
         case (m_acc[a])
            2'b01: begin exp_ld[a] = 1; exp_val = {8'h00, d}; tag = "R3"; end
            2'b10: begin exp_ld[a] = 1; exp_val = {d, 8'h00}; tag = "R3"; end
            default: begin
               tag = "R4";
               if (m_wrhi[a]) begin exp_ld[a] = 1; exp_val = {d, m_hold[a]}; end
               else m_hold[a] = d;
               m_wrhi[a] = !m_wrhi[a];
            end
         endcase
         chk(ch_load == exp_ld, tag, "load strobe", int'(ch_load), int'(exp_ld));
         if (exp_ld != 0)
            chk(ch_load_val[a*16 +: 16] == exp_val, tag, "load value",
                int'(ch_load_val[a*16 +: 16]), int'(exp_val));
      end else begin
         chk(ch_load == 0, "R1", "no load on command", int'(ch_load), 0);
         if (d[7:6] != 2'b11) begin
            if (d[5:4] == 0) model_latch(d[7:6]);
            else begin
               m_acc[d[7:6]] = d[5:4]; m_mode[d[7:6]] = d[3:1]; m_bcd[d[7:6]] = d[0];
               m_wrhi[d[7:6]] = 0; m_rdhi[d[7:6]] = 0;
            end
         end else begin
            for (int c = 0; c < 3; c++) if (d[c+1]) begin
               if (!d[5]) model_latch(c);
               if (!d[4] && !m_slat[c]) begin
                  m_slat[c] = 1;
                  m_sval[c] = {lout[c], 1'b0, m_acc[c], m_mode[c], m_bcd[c]};
               end
            end
         end
      end
      @(posedge clk); #1;
      wr_en = 0;
      for (int c = 0; c < 3; c++) begin
         chk(ch_mode[c*3 +: 3] == m_mode[c], "R1", "mode output", int'(ch_mode[c*3 +: 3]), int'(m_mode[c]));
         chk(ch_bcd[c] == m_bcd[c], "R1", "bcd output", int'(ch_bcd[c]), int'(m_bcd[c]));
      end
   endtask

   task automatic do_rd(input logic [1:0] a, input string force_tag);
      logic [7:0] exp;
      string tag;
      @(negedge clk);
      addr = a; rd_en = 1;
      #(HALF - 1);
      if (a == 3) begin exp = 0; tag = "R9"; end
      else if (m_slat[a]) begin exp = m_sval[a]; m_slat[a] = 0; tag = "R6"; end
      else if (m_clat[a] != 0) begin
         tag = "R7";
         if (m_clat[a] == 2) begin exp = m_cval[a][15:8]; m_clat[a] = 0; end
         else if (m_clat[a] == 1) begin exp = m_cval[a][7:0]; m_clat[a] = 0; end
         else begin exp = m_cval[a][7:0]; m_clat[a] = 2; end
      end else begin
         tag = "R8";
         if (m_acc[a] == 1) exp = lcnt[a][7:0];
         else if (m_acc[a] == 2) exp = lcnt[a][15:8];
         else begin exp = m_rdhi[a] ? lcnt[a][15:8] : lcnt[a][7:0]; m_rdhi[a] = !m_rdhi[a]; end
      end
      if (force_tag != "") tag = force_tag;
      chk(rdata == exp, tag, "read data", int'(rdata), int'(exp));
      @(posedge clk); #1;
      rd_en = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      for (int c = 0; c < 3; c++) lcnt[c] = 16'h0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R10: reset state
      chk(ch_mode == 0, "R10", "mode after reset", int'(ch_mode), 0);
      chk(ch_load == 0, "R10", "no load after reset", int'(ch_load), 0);
      lcnt[0] = 16'hA55A;
      do_rd(0, "R10");
      do_rd(0, "R10");
      // R1/R3: low-only, then high-only on channel 1
      do_wr(3, 8'h55);
      do_wr(1, 8'h34);
      do_wr(3, 8'h64);
      do_wr(1, 8'h12);
      lcnt[1] = 16'hBEEF;
      do_rd(1, "R8");
      // R4: pair on channel 2
      do_wr(3, 8'hB6);
      do_wr(2, 8'h78);
      do_wr(2, 8'h56);
      do_wr(2, 8'h9A);
      do_wr(2, 8'hBC);
      // R2: latch, ignored second latch, mode kept
      lcnt[2] = 16'h1111;
      do_wr(3, 8'h80);
      lcnt[2] = 16'h2222;
      do_wr(3, 8'h80);
      chk(ch_mode[8:6] == 3'd3, "R2", "mode kept on latch", int'(ch_mode[8:6]), 3);
      do_rd(2, "R2");
      do_rd(2, "R7");
      do_rd(2, "R8");
      // R5/R6: snapshot of status and count on channel 0
      lout[0] = 1;
      lcnt[0] = 16'h4321;
      do_wr(3, 8'hC2);
      lcnt[0] = 16'h0000;
      do_rd(0, "R5");
      do_rd(0, "R6");
      do_rd(0, "R7");
      do_rd(3, "R9");
      do_wr(2, 8'h01);
      do_rd(3, "R9");
      do_wr(2, 8'h02);
      // random traffic
      for (int i = 0; i < 800; i++) begin
         int k;
         for (int c = 0; c < 3; c++) lcnt[c] = 16'($urandom);
         lout = 3'($urandom);
         k = $urandom_range(0, 99);
         if (k < 40) do_rd(2'($urandom_range(0, 3)), "");
         else if (k < 70) do_wr(2'($urandom_range(0, 2)), 8'($urandom));
         else if (k < 85) do_wr(3, {2'($urandom_range(0, 2)), 6'($urandom)});
         else do_wr(3, {2'b11, 6'($urandom)});
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule